// File: doc/BRIEF.md
# Serial Control Port for a Frequency Synthesizer

This block is a two-wire (I2C) target that keeps the programming registers of a phase-locked frequency synthesizer and returns a one-byte status word. A bus controller writes byte pairs to it. The first byte of each pair names its own register group through its most significant bit, so the block has no register pointer. Any number of pairs may follow one address byte, until a STOP ends the transfer.

The 15-bit main divide ratio arrives in two bytes. It is held in a staging register so that the loop never sees a half-updated ratio. A complete pair, or the STOP that ends the transfer, moves the staged upper bits into the live ratio. The status byte carries a power-on flag and the lock indication. A STOP that ends a read clears the power-on flag. Test modes can force the lock indication and select what the charge pump and the general port do.

Both bus lines are resynchronised to the system clock and filtered before any bit or condition is decoded. Short spikes therefore cannot create a false START or STOP. SDA is driven open-drain: `sda_oe` high means the line is pulled low.

Top module: `synth_ctrl_i2c`

## Requirements
- R1: The block responds to the 7-bit address 1100 0 followed by `addr_sel[1]` and `addr_sel[0]`. The eighth bit is 0 for a write and 1 for a read. On a match the block pulls SDA low in the acknowledge slot. On a mismatch it never drives SDA until the next START.
- R2: In the first byte of a pair, bit 7 = 0 selects the divide group. Bits 6..0 of that byte are ratio bits 14..8. Bit 7 = 1 selects the control group: bits 6..5 load the charge-pump code and bits 4..0 load the reference ratio code.
- R3: The second byte of a control pair loads the test mode from bits 7..5, the power code from bits 4..2, the reference-buffer enable from bit 1 and the port bit from bit 0.
- R4: Further pairs in the same transfer are typed by the same rule, with no new address byte.
- R5: `div_ratio` stays unchanged after a divide-group first byte alone. It takes all 15 new bits as soon as the second byte is complete. If a STOP arrives before that second byte, the STOP loads only bits 14..8 and keeps bits 7..0.
- R6: A STOP that arrives part-way through a byte discards that byte, so every register keeps its earlier value.
- R7: The block acknowledges every data byte of a matched write. It asserts `sda_oe` only while SCL is low.
- R8: In a read, each status byte is {POR, FL, 000000}. The block sends another status byte whenever the controller acknowledges. After a controller no-acknowledge it leaves SDA released until the next START.
- R9: POR reads 1 after reset. Write transfers leave it unchanged. It clears at the STOP that ends a read addressed to this block.
- R10: The reset values are: divide ratio 0, reference code 0, charge-pump code 0, test mode 000, power code 000, reference-buffer enable 1, port bit 0.
- R11: FL follows `lock_in` in test modes 000 and 100. FL reads 0 in modes 001, 010, 101 and 110, and 1 in modes 011 and 111. `cp_mode` equals test-mode bits 1..0 (00 normal, 01 sink, 10 source, 11 off). `port_src` is 01 (divider/2) in mode 100, 10 (comparison clock) in modes 101 to 111, and 00 (static port bit) otherwise.
- R12: A pulse on SDA or SCL shorter than `FILT_LEN` system clocks is ignored. Such a pulse on SDA while SCL is high does not end or restart a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| addr_sel | input | 2 | Low two bits of the target address |
| lock_in | input | 1 | Lock flag from the phase detector |
| div_ratio | output | 15 | Main divide ratio |
| ref_code | output | 5 | Reference ratio code |
| cp_code | output | 2 | Charge-pump current code |
| test_mode | output | 3 | Test mode |
| pwr_code | output | 3 | Mixer power code |
| refbuf_en | output | 1 | Reference buffer enable |
| port_bit | output | 1 | General port state |
| cp_mode | output | 2 | Charge-pump override: 00 normal, 01 sink, 10 source, 11 off |
| port_src | output | 2 | Port source: 00 port bit, 01 divider/2, 10 comparison clock |

## Verification
The bench samples `div_ratio` at three points: between the two divide bytes, just after the second byte, and after a STOP that follows a lone first byte. A design that commits too early shows a mixed ratio at the first point. A design that ignores the STOP keeps a stale upper half at the third.

The bench also checks these cases:
- A STOP placed three bits into a byte. A design that writes partial bytes changes a register here.
- A foreign address. A design that answers it shows an acknowledge or a drive on SDA.
- A 2-clock SDA spike while SCL is high, inside a data byte. Unfiltered decode would see a false START and STOP and lose the write.
- The POR flag after a write and after a read.
- All eight test modes, read back with both lock levels.

// File: rtl/synth_ctrl_pkg.sv
// Shared widths, encodings and state type for the synthesizer control port.
// Assumes: field widths are fixed by the byte layout of the bus protocol.
package synth_ctrl_pkg;
    localparam int DIV_W    = 15;
    localparam int BYTE_W   = 8;
    localparam int DIV_HI_W = DIV_W - BYTE_W;
    localparam int REF_W    = 5;
    localparam int CP_W     = 2;
    localparam int TM_W     = 3;
    localparam int PWR_W    = 3;
    localparam int SEL_W    = 2;
    localparam int ADDR_W   = 7;
    localparam int CNT_W    = $clog2(BYTE_W);
    localparam logic [ADDR_W-SEL_W-1:0] ADDR_FIXED = 5'b11000;

    typedef enum logic [1:0] {
        CP_NORMAL = 2'b00,
        CP_SINK   = 2'b01,
        CP_SOURCE = 2'b10,
        CP_OFF    = 2'b11
    } cp_drive_t;

    typedef enum logic [1:0] {
        PORT_STATIC   = 2'b00,
        PORT_DIV_HALF = 2'b01,
        PORT_COMP     = 2'b10
    } port_src_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WDATA_ACK,
        ST_RDATA, ST_RDATA_ACK, ST_IGNORE
    } xfer_state_t;
endpackage

// File: rtl/scl_sda_conditioner.sv
// Resynchronises SCL and SDA, rejects pulses shorter than FILT_LEN clocks,
// and produces one-cycle SCL edge, START and STOP strobes.
// Assumes: both lines idle high; clk is much faster than SCL.
module scl_sda_conditioner #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_flt,
    output logic sda_flt,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int RUN_W = $clog2(FILT_LEN + 1);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] flt;
    logic [LINES-1:0] flt_q;

    assign raw = {scl_raw, sda_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [1:0]       sync_q;
        logic [RUN_W-1:0] run_cnt;
        logic             line_q;

        // two-flop resynchronisation of the raw line
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= 2'b11;
            else        sync_q <= {sync_q[0], raw[g]};
        end

        // accept a new level only after FILT_LEN consecutive samples
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q  <= 1'b1;
                run_cnt <= '0;
            end else if (sync_q[1] == line_q) begin
                run_cnt <= '0;
            end else if (run_cnt == RUN_W'(FILT_LEN - 1)) begin
                line_q  <= sync_q[1];
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end

        assign flt[g] = line_q;
    end

    // previous filtered levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) flt_q <= '1;
        else        flt_q <= flt;
    end

    assign scl_flt   = flt[1];
    assign sda_flt   = flt[0];
    assign scl_rise  = flt[1] & ~flt_q[1];
    assign scl_fall  = ~flt[1] & flt_q[1];
    assign start_evt = flt[1] & flt_q[1] & flt_q[0] & ~flt[0];
    assign stop_evt  = flt[1] & flt_q[1] & ~flt_q[0] & flt[0];
endmodule

// File: rtl/i2c_xfer_engine.sv
// Bit and byte sequencer of the bus target: address match, acknowledge,
// write byte strobes, status byte shifting and controller-ack handling.
// Assumes: conditioned strobes from scl_sda_conditioner; sda_drive=1 pulls low.
module i2c_xfer_engine
    import synth_ctrl_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sda_flt,
    input  logic                   scl_rise,
    input  logic                   scl_fall,
    input  logic                   start_evt,
    input  logic                   stop_evt,
    input  logic [SEL_W-1:0]       addr_sel,
    input  logic [BYTE_W-1:0]      status_byte,
    output logic                   sda_drive,
    output logic                   wr_stb,
    output logic [BYTE_W-1:0]      wr_byte,
    output logic                   read_close
);
    xfer_state_t       state;
    logic [CNT_W-1:0]  bit_cnt;
    logic              got_byte;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rw_bit;
    logic              rd_sel;
    logic              mack;
    logic              last_bit;
    logic [ADDR_W-1:0] my_addr;

    assign last_bit   = (bit_cnt == CNT_W'(BYTE_W - 1));
    assign my_addr    = {ADDR_FIXED, addr_sel};
    assign read_close = stop_evt & rd_sel;

    // transfer state, bit counting, shifting and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            got_byte  <= 1'b0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rw_bit    <= 1'b0;
            rd_sel    <= 1'b0;
            mack      <= 1'b0;
            sda_drive <= 1'b0;
            wr_stb    <= 1'b0;
            wr_byte   <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_evt) begin
                state     <= ST_ADDR;
                bit_cnt   <= '0;
                got_byte  <= 1'b0;
                sda_drive <= 1'b0;
                rd_sel    <= 1'b0;
            end else if (stop_evt) begin
                state     <= ST_IDLE;
                got_byte  <= 1'b0;
                sda_drive <= 1'b0;
                rd_sel    <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_flt};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) begin
                                got_byte <= 1'b1;
                                if (state == ST_WDATA) begin
                                    wr_stb  <= 1'b1;
                                    wr_byte <= {rx_sh[BYTE_W-2:0], sda_flt};
                                end
                            end
                        end else if (scl_fall && got_byte) begin
                            got_byte <= 1'b0;
                            bit_cnt  <= '0;
                            if (state == ST_WDATA) begin
                                state     <= ST_WDATA_ACK;
                                sda_drive <= 1'b1;
                            end else if (rx_sh[BYTE_W-1:1] == my_addr) begin
                                state     <= ST_ADDR_ACK;
                                sda_drive <= 1'b1;
                                rw_bit    <= rx_sh[0];
                                rd_sel    <= rx_sh[0];
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_bit) begin
                                state     <= ST_RDATA;
                                tx_sh     <= status_byte;
                                sda_drive <= ~status_byte[BYTE_W-1];
                            end else begin
                                state     <= ST_WDATA;
                                sda_drive <= 1'b0;
                            end
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            state     <= ST_WDATA;
                            sda_drive <= 1'b0;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (last_bit) got_byte <= 1'b1;
                        end else if (scl_fall) begin
                            if (got_byte) begin
                                got_byte  <= 1'b0;
                                bit_cnt   <= '0;
                                sda_drive <= 1'b0;
                                state     <= ST_RDATA_ACK;
                            end else begin
                                tx_sh     <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_drive <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_flt;
                        end else if (scl_fall) begin
                            if (mack) begin
                                state     <= ST_RDATA;
                                tx_sh     <= status_byte;
                                sda_drive <= ~status_byte[BYTE_W-1];
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/synth_ctrl_regs.sv
// Control registers: byte-pair typing, staged divide-ratio commit, POR flag,
// and test-mode overrides of lock flag, charge pump and port source.
// Assumes: wr_stb pulses once per complete, acknowledged write data byte.
module synth_ctrl_regs
    import synth_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  logic [BYTE_W-1:0]    wr_byte,
    input  logic                 xfer_begin,
    input  logic                 stop_evt,
    input  logic                 read_close,
    input  logic                 lock_in,
    output logic [DIV_W-1:0]     div_ratio,
    output logic [REF_W-1:0]     ref_code,
    output logic [CP_W-1:0]      cp_code,
    output logic [TM_W-1:0]      test_mode,
    output logic [PWR_W-1:0]     pwr_code,
    output logic                 refbuf_en,
    output logic                 port_bit,
    output logic [1:0]           cp_mode,
    output logic [1:0]           port_src,
    output logic [BYTE_W-1:0]    status_byte,
    output logic                 por_flag
);
    logic                pair_second;
    logic                pair_ctrl;
    logic                hi_pend;
    logic [DIV_HI_W-1:0] hi_stage;
    logic                fl_eff;

    // pair typing, staging and register loads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_second <= 1'b0;
            pair_ctrl   <= 1'b0;
            hi_pend     <= 1'b0;
            hi_stage    <= '0;
            div_ratio   <= '0;
            ref_code    <= '0;
            cp_code     <= '0;
            test_mode   <= '0;
            pwr_code    <= '0;
            refbuf_en   <= 1'b1;
            port_bit    <= 1'b0;
        end else begin
            if (xfer_begin || stop_evt) pair_second <= 1'b0;
            if (stop_evt && hi_pend) begin
                div_ratio[DIV_W-1:BYTE_W] <= hi_stage;
                hi_pend <= 1'b0;
            end
            if (wr_stb) begin
                if (!pair_second) begin
                    pair_second <= 1'b1;
                    pair_ctrl   <= wr_byte[BYTE_W-1];
                    if (wr_byte[BYTE_W-1]) begin
                        cp_code  <= wr_byte[REF_W+CP_W-1:REF_W];
                        ref_code <= wr_byte[REF_W-1:0];
                    end else begin
                        hi_stage <= wr_byte[DIV_HI_W-1:0];
                        hi_pend  <= 1'b1;
                    end
                end else begin
                    pair_second <= 1'b0;
                    if (pair_ctrl) begin
                        {test_mode, pwr_code, refbuf_en, port_bit} <= wr_byte;
                    end else begin
                        div_ratio <= {hi_stage, wr_byte};
                        hi_pend   <= 1'b0;
                    end
                end
            end
        end
    end

    // power-on flag, cleared by the STOP that closes a read
    always_ff @(posedge clk) begin
        if (!rst_n)          por_flag <= 1'b1;
        else if (read_close) por_flag <= 1'b0;
    end

    // lock flag as reported, with test-mode forcing
    always_comb begin
        case (test_mode[1:0])
            2'b00:   fl_eff = lock_in;
            2'b11:   fl_eff = 1'b1;
            default: fl_eff = 1'b0;
        endcase
    end

    // port source selection from test mode
    always_comb begin
        if (test_mode == 3'b100)  port_src = PORT_DIV_HALF;
        else if (test_mode[2])    port_src = PORT_COMP;
        else                      port_src = PORT_STATIC;
    end

    assign cp_mode     = test_mode[1:0];
    assign status_byte = {por_flag, fl_eff, {(BYTE_W-2){1'b0}}};
endmodule

// File: rtl/synth_ctrl_i2c.sv
// Top of the synthesizer serial control port: line conditioning, transfer
// sequencing and register file. Assumes an external open-drain SDA pad.
module synth_ctrl_i2c
    import synth_ctrl_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    input  logic [SEL_W-1:0] addr_sel,
    input  logic             lock_in,
    output logic [DIV_W-1:0] div_ratio,
    output logic [REF_W-1:0] ref_code,
    output logic [CP_W-1:0]  cp_code,
    output logic [TM_W-1:0]  test_mode,
    output logic [PWR_W-1:0] pwr_code,
    output logic             refbuf_en,
    output logic             port_bit,
    output logic [1:0]       cp_mode,
    output logic [1:0]       port_src
);
    logic              scl_flt;
    logic              sda_flt;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_byte;
    logic              read_close;
    logic [BYTE_W-1:0] status_byte;
    logic              por_flag;

    scl_sda_conditioner #(.FILT_LEN(FILT_LEN)) i_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_flt   (scl_flt),
        .sda_flt   (sda_flt),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_xfer_engine i_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_flt     (sda_flt),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .addr_sel    (addr_sel),
        .status_byte (status_byte),
        .sda_drive   (sda_oe),
        .wr_stb      (wr_stb),
        .wr_byte     (wr_byte),
        .read_close  (read_close)
    );

    synth_ctrl_regs i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_byte     (wr_byte),
        .xfer_begin  (start_evt),
        .stop_evt    (stop_evt),
        .read_close  (read_close),
        .lock_in     (lock_in),
        .div_ratio   (div_ratio),
        .ref_code    (ref_code),
        .cp_code     (cp_code),
        .test_mode   (test_mode),
        .pwr_code    (pwr_code),
        .refbuf_en   (refbuf_en),
        .port_bit    (port_bit),
        .cp_mode     (cp_mode),
        .port_src    (port_src),
        .status_byte (status_byte),
        .por_flag    (por_flag)
    );
endmodule

// File: rtl/synth_ctrl_i2c_chk.sv
// Temporal checks of the control port, bound into synth_ctrl_i2c.
// Assumes: strobes and flags are the top's internal nets of the same names.
module synth_ctrl_i2c_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_flt,
    input logic        sda_oe,
    input logic        stop_evt,
    input logic        wr_stb,
    input logic        por_flag,
    input logic [14:0] div_ratio,
    input logic [14:0] ctrl_bits
);
    // divide ratio moves only after a data byte or a STOP (R5)
    p_div_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_ratio) |-> ($past(wr_stb) || $past(stop_evt)));

    // control fields move only after a received data byte (R2, R3)
    p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_bits) |-> $past(wr_stb));

    // SDA pulled low only while SCL is low (R7)
    p_drive_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_flt);

    // SDA released after a STOP (R8)
    p_release_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_evt) |-> !sda_oe);

    // POR never sets again after reset (R9)
    p_por_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(por_flag));

    // POR only clears at a STOP (R9)
    p_por_clear_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_flag) |-> $past(stop_evt));
endmodule

bind synth_ctrl_i2c synth_ctrl_i2c_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_flt   (scl_flt),
    .sda_oe    (sda_oe),
    .stop_evt  (stop_evt),
    .wr_stb    (wr_stb),
    .por_flag  (por_flag),
    .div_ratio (div_ratio),
    .ctrl_bits ({ref_code, cp_code, test_mode, pwr_code, refbuf_en, port_bit})
);

// File: tb/test_synth_ctrl_i2c.sv
`timescale 1ns/1ps
module test_synth_ctrl_i2c;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic glitch = 1'b0;
    logic [1:0] addr_sel = 2'b00;
    logic lock_in = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [14:0] div_ratio;
    logic [4:0] ref_code;
    logic [1:0] cp_code;
    logic [2:0] test_mode;
    logic [2:0] pwr_code;
    logic refbuf_en;
    logic port_bit;
    logic [1:0] cp_mode;
    logic [1:0] port_src;

    assign sda_line = m_sda & ~sda_oe & ~glitch;

    synth_ctrl_i2c i_synth_ctrl_i2c (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .addr_sel(addr_sel), .lock_in(lock_in),
        .div_ratio(div_ratio), .ref_code(ref_code), .cp_code(cp_code),
        .test_mode(test_mode), .pwr_code(pwr_code), .refbuf_en(refbuf_en),
        .port_bit(port_bit), .cp_mode(cp_mode), .port_src(port_src)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit oe_seen = 1'b0;
    always @(negedge clk) if (sda_oe) oe_seen = 1'b1;

    // expected-state model
    logic [14:0] e_div = '0;
    logic [6:0]  e_stage = '0;
    logic        e_pend = 1'b0;
    logic [4:0]  e_ref = '0;
    logic [1:0]  e_cp = '0;
    logic [2:0]  e_tm = '0;
    logic [2:0]  e_pwr = '0;
    logic        e_re = 1'b1;
    logic        e_p0 = 1'b0;
    logic        e_por = 1'b1;
    logic        e_second = 1'b0;
    logic        e_ctrl = 1'b0;
    logic [7:0]  txb [0:7];

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic f_fl(input logic [2:0] tm, input logic lk);
        if (tm[1:0] == 2'b00) return lk;
        if (tm[1:0] == 2'b11) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [1:0] f_port(input logic [2:0] tm);
        if (tm == 3'b100) return 2'b01;
        if (tm[2]) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [6:0] my_addr(input logic [1:0] s);
        return {5'b11000, s};
    endfunction

    task automatic model_byte(input logic [7:0] b);
        if (!e_second) begin
            e_second = 1'b1;
            e_ctrl = b[7];
            if (b[7]) begin e_cp = b[6:5]; e_ref = b[4:0]; end
            else begin e_stage = b[6:0]; e_pend = 1'b1; end
        end else begin
            e_second = 1'b0;
            if (e_ctrl) {e_tm, e_pwr, e_re, e_p0} = b;
            else begin e_div = {e_stage, b}; e_pend = 1'b0; end
        end
    endtask

    task automatic model_stop();
        e_second = 1'b0;
        if (e_pend) begin e_div[14:8] = e_stage; e_pend = 1'b0; end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " div_ratio"}, 32'(div_ratio), 32'(e_div));
        chk({tag, " ref_code"}, 32'(ref_code), 32'(e_ref));
        chk({tag, " cp_code"}, 32'(cp_code), 32'(e_cp));
        chk({tag, " test_mode"}, 32'(test_mode), 32'(e_tm));
        chk({tag, " pwr_code"}, 32'(pwr_code), 32'(e_pwr));
        chk({tag, " refbuf_en"}, 32'(refbuf_en), 32'(e_re));
        chk({tag, " port_bit"}, 32'(port_bit), 32'(e_p0));
        chk({tag, " R11 cp_mode"}, 32'(cp_mode), 32'(e_tm[1:0]));
        chk({tag, " R11 port_src"}, 32'(port_src), 32'(f_port(e_tm)));
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
        e_second = 1'b0;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait(); qwait();
        model_stop();
    endtask

    task automatic bit_out(input logic b, input logic g);
        m_sda = b; qwait();
        m_scl = 1'b1; qwait();
        if (g) begin glitch = 1'b1; repeat (2) @(negedge clk); glitch = 1'b0; end
        qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        b = sda_line; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, input int gbit, output logic ack);
        logic nack;
        for (int i = 7; i >= 0; i--) bit_out(b[i], i == gbit);
        bit_in(nack);
        ack = ~nack;
    endtask

    task automatic recv_byte(input logic ackm, output logic [7:0] b);
        logic v;
        for (int i = 7; i >= 0; i--) begin bit_in(v); b[i] = v; end
        bit_out(~ackm, 1'b0);
    endtask

    task automatic wr_xfer(input logic [6:0] a, input int n, input logic exp_ack);
        logic ack;
        oe_seen = 1'b0;
        bus_start();
        send_byte({a, 1'b0}, -1, ack);
        chk("R1 address ack", 32'(ack), 32'(exp_ack));
        for (int k = 0; k < n; k++) begin
            send_byte(txb[k], -1, ack);
            chk("R7 data byte ack", 32'(ack), 32'(exp_ack));
            if (exp_ack) model_byte(txb[k]);
        end
        bus_stop();
        if (!exp_ack) chk("R1 no SDA drive on mismatch", 32'(oe_seen), 32'd0);
    endtask

    task automatic rd_xfer(input int n);
        logic ack;
        logic [7:0] b;
        logic [7:0] exp;
        logic rel;
        bus_start();
        send_byte({my_addr(addr_sel), 1'b1}, -1, ack);
        chk("R1 read address ack", 32'(ack), 32'd1);
        exp = {e_por, f_fl(e_tm, lock_in), 6'b0};
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            chk("R8/R9/R11 status byte", 32'(b), 32'(exp));
        end
        oe_seen = 1'b0;
        bit_in(rel);
        chk("R8 released after nack", 32'(rel), 32'd1);
        chk("R8 no drive after nack", 32'(oe_seen), 32'd0);
        bus_stop();
        e_por = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_all("R10 reset");

        // R9: write leaves POR set, read shows it, then cleared
        addr_sel = 2'b10;
        txb[0] = 8'hA3; txb[1] = 8'h5A;
        wr_xfer(my_addr(addr_sel), 2, 1'b1);
        check_all("R2/R3 control pair");
        lock_in = 1'b1;
        rd_xfer(3);
        rd_xfer(1);

        // R1: foreign address is ignored
        txb[0] = 8'h80; txb[1] = 8'hFF;
        wr_xfer(my_addr(2'b01), 2, 1'b0);
        check_all("R1 mismatch leaves regs");

        // R5: staged commit of the divide ratio
        txb[0] = 8'h12; txb[1] = 8'h34;
        wr_xfer(my_addr(addr_sel), 2, 1'b1);
        check_all("R5 full pair");
        bus_start();
        send_byte({my_addr(addr_sel), 1'b0}, -1, ack);
        send_byte(8'h65, -1, ack); model_byte(8'h65);
        chk("R5 hold after first byte", 32'(div_ratio), 32'h1234);
        send_byte(8'hC7, -1, ack); model_byte(8'hC7);
        chk("R5 commit on second byte", 32'(div_ratio), 32'h65C7);
        send_byte(8'h0F, -1, ack); model_byte(8'h0F);
        chk("R5 hold before STOP", 32'(div_ratio), 32'h65C7);
        bus_stop();
        chk("R5 STOP commits high half", 32'(div_ratio), 32'h0FC7);

        // R6: STOP three bits into a byte
        bus_start();
        send_byte({my_addr(addr_sel), 1'b0}, -1, ack);
        bit_out(1'b1, 1'b0); bit_out(1'b1, 1'b0); bit_out(1'b1, 1'b0);
        bus_stop();
        check_all("R6 partial byte discarded");

        // R4: several pairs in one transfer
        txb[0] = 8'h7F; txb[1] = 8'hFF; txb[2] = 8'hC1; txb[3] = 8'h1D;
        txb[4] = 8'h9E; txb[5] = 8'h82;
        wr_xfer(my_addr(addr_sel), 6, 1'b1);
        check_all("R4 three pairs");

        // R12: 2-clock SDA spike while SCL high inside a data byte
        bus_start();
        send_byte({my_addr(addr_sel), 1'b0}, -1, ack);
        send_byte(8'hE5, 6, ack); model_byte(8'hE5);
        chk("R12 ack after spike", 32'(ack), 32'd1);
        send_byte(8'h3C, -1, ack); model_byte(8'h3C);
        chk("R12 second byte ack", 32'(ack), 32'd1);
        bus_stop();
        check_all("R12 write survives spike");

        // R11: all test modes with both lock levels
        for (int tm = 0; tm < 8; tm++) begin
            txb[0] = 8'h80; txb[1] = {3'(tm), 5'b00010};
            wr_xfer(my_addr(addr_sel), 2, 1'b1);
            check_all("R11 test mode outputs");
            for (int lk = 0; lk < 2; lk++) begin
                lock_in = lk[0];
                rd_xfer(1);
            end
        end

        // random transfers
        for (int it = 0; it < 16; it++) begin
            int np;
            logic wrong;
            addr_sel = 2'($urandom_range(0, 3));
            wrong = ($urandom_range(0, 3) == 0);
            np = $urandom_range(1, 5);
            for (int k = 0; k < np; k++) txb[k] = 8'($urandom);
            wr_xfer(wrong ? my_addr(~addr_sel) : my_addr(addr_sel), np, ~wrong);
            check_all("R2/R3/R4/R5 random write");
            if ($urandom_range(0, 2) == 0) begin
                lock_in = 1'($urandom);
                rd_xfer($urandom_range(1, 2));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule